// File: doc/BRIEF.md
# Indexed DMA Channel Command Front End

This block is the host-facing register front end of a multi-channel DMA controller. Software reaches every channel register through just two byte-wide ports. A byte written to the function port names an operation and a channel. After that, each access to the execute port moves one byte of the selected register in or out. An internal byte counter picks which byte that is. The operation code alone decides how many bytes the sequence has and which way they flow.

The block keeps a set of registers for each channel: a 24-bit memory address, a 16-bit transfer count, a 16-bit I/O port number, an 8-bit mode, a 4-bit arbitration level and a mask bit. All of them are presented as flat vectors to the transfer engine beside it. The engine reports terminal-count events back on a per-channel pulse input. The block collects these events into sticky flags, and the host reads and clears them through a status operation.

Top module: `dma_cmd_front`

## Requirements
- R1: The function port is at offset 0x18 and the execute port at 0x1A. Writes to any other offset change nothing. A function-port byte holds the operation in bits 7:4 and the channel in bits 3:0. Every function write restarts the byte counter at byte 0, so a sequence left half done is abandoned.
- R2: Operation 0x2 writes the channel's 24-bit memory address. Three execute writes supply bits 7:0 first, then bits 15:8, then bits 23:16.
- R3: Operation 0x3 reads back the channel's memory address. Three execute reads return bits 7:0 first, then bits 15:8, then bits 23:16.
- R4: Operation 0x4 writes the 16-bit count with two execute writes, low byte first. Operation 0x5 reads it back with two execute reads in the same byte order.
- R5: Operation 0x0 writes the 16-bit I/O port number with two execute writes, low byte first.
- R6: Operation 0x7 stores one execute byte as the channel mode. Operation 0x8 stores bits 3:0 of one execute byte as the arbitration level.
- R7: Operation 0x9 sets the channel's mask bit and 0xA clears it, both on the function write alone. A channel number of NCH or above changes no mask and no register.
- R8: Once a sequence has used all its bytes, further execute writes are ignored and further execute reads return 0x00. An execute write during a read operation is ignored and does not advance the byte counter. An execute read during a write operation returns 0x00.
- R9: Operation 0xD sets every mask bit, zeroes every channel register and every terminal-count flag, and leaves no sequence active, so execute accesses that follow have no effect. Reset gives the same state.
- R10: Operation 0x6 makes every execute read return the terminal-count flags, with bit i for channel i. The flags returned are cleared by that read. A terminal-count pulse that arrives in the same cycle as the read stays set.
- R11: The read data output is 0x00 in any cycle without an execute read, including reads of the function port and all write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWr | input | 1 | Host write strobe, one access per cycle |
| hostRd | input | 1 | Host read strobe, ignored while hostWr is high |
| hostAddr | input | ADDR_W (5) | Host byte offset |
| hostWdata | input | 8 | Host write byte |
| hostRdata | output | 8 | Host read byte, combinational in the read cycle |
| tcPulse | input | NCH (8) | Terminal-count event per channel from the engine |
| chAddr | output | 24*NCH (192) | Memory address of channel i at bits 24i+23:24i |
| chCount | output | 16*NCH (128) | Transfer count per channel |
| chIoPort | output | 16*NCH (128) | I/O port number per channel |
| chMode | output | 8*NCH (64) | Mode byte per channel |
| chArb | output | 4*NCH (32) | Arbitration level per channel |
| chMask | output | NCH (8) | Mask bit per channel, 1 = masked |

## Verification
A terminal-count pulse from the engine can arrive in the same cycle in which the host reads status and clears the flags. The bench sets a pair of flags first. It then raises a pulse for a third channel in the very cycle of the status read. The scoreboard expects that read to return only the earlier pair. The next status read must then return the third channel alone, and the read after that must return zero.

// File: rtl/dma_cmd_pkg.sv
package dma_cmd_pkg;

  // operation codes carried in bits 7:4 of a function-port byte
  localparam logic [3:0] OP_SET_IO   = 4'h0;
  localparam logic [3:0] OP_SET_ADDR = 4'h2;
  localparam logic [3:0] OP_GET_ADDR = 4'h3;
  localparam logic [3:0] OP_SET_CNT  = 4'h4;
  localparam logic [3:0] OP_GET_CNT  = 4'h5;
  localparam logic [3:0] OP_GET_STAT = 4'h6;
  localparam logic [3:0] OP_SET_MODE = 4'h7;
  localparam logic [3:0] OP_SET_ARB  = 4'h8;
  localparam logic [3:0] OP_MASK     = 4'h9;
  localparam logic [3:0] OP_UNMASK   = 4'hA;
  localparam logic [3:0] OP_CLEAR    = 4'hD;

  // strobes and selection handed from control to datapath
  typedef struct packed {
    logic [3:0] op;        // latched operation
    logic [3:0] chan;      // latched channel
    logic [1:0] byteIdx;   // current byte of the sequence
    logic       wrGo;      // qualified execute write
    logic       rdGo;      // qualified execute read
    logic [3:0] fnChan;    // channel field of the current function write
    logic       maskStb;
    logic       unmaskStb;
    logic       clearStb;
  } cmd_stb_t;

  // number of execute bytes an operation expects (status is open-ended)
  function automatic logic [2:0] opLen(input logic [3:0] op);
    case (op)
      OP_SET_ADDR, OP_GET_ADDR:          opLen = 3'd3;
      OP_SET_CNT, OP_GET_CNT, OP_SET_IO: opLen = 3'd2;
      OP_SET_MODE, OP_SET_ARB:           opLen = 3'd1;
      default:                           opLen = 3'd0;
    endcase
  endfunction

  function automatic logic isReadOp(input logic [3:0] op);
    isReadOp = (op == OP_GET_ADDR) || (op == OP_GET_CNT) || (op == OP_GET_STAT);
  endfunction

endpackage

// File: rtl/dma_cmd_ctrl.sv
module dma_cmd_ctrl
  import dma_cmd_pkg::*;
#(
  parameter int NCH = 8,
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] FN_OFS = ADDR_W'(8'h18),
  parameter logic [ADDR_W-1:0] EXE_OFS = ADDR_W'(8'h1A)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [7:0]        hostWdata,
  output cmd_stb_t          stb
);

  logic [3:0] opQ, chanQ;
  logic [1:0] idxQ;
  logic fnWr, exeWrRaw, exeRdRaw, chanOk, newChanOk, rdOp, inRange;
  logic wrGo, rdGo, advance;
  logic [3:0] newOp, newChan;

  always_comb begin
    fnWr      = hostWr && (hostAddr == FN_OFS);
    exeWrRaw  = hostWr && (hostAddr == EXE_OFS);
    exeRdRaw  = hostRd && !hostWr && (hostAddr == EXE_OFS);
    newOp     = hostWdata[7:4];
    newChan   = hostWdata[3:0];
    chanOk    = int'(chanQ) < NCH;
    newChanOk = int'(newChan) < NCH;
    rdOp      = isReadOp(opQ);
    inRange   = (opQ == OP_GET_STAT) || (({1'b0, idxQ} < opLen(opQ)) && chanOk);
    wrGo      = exeWrRaw && inRange && !rdOp;
    rdGo      = exeRdRaw && inRange && rdOp;
    advance   = (wrGo || rdGo) && (opQ != OP_GET_STAT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ   <= OP_CLEAR;
      chanQ <= '0;
      idxQ  <= '0;
    end else if (fnWr) begin
      opQ   <= newOp;
      chanQ <= newChan;
      idxQ  <= '0;
    end else if (advance) begin
      idxQ  <= idxQ + 2'd1;
    end
  end

  always_comb begin
    stb.op        = opQ;
    stb.chan      = chanQ;
    stb.byteIdx   = idxQ;
    stb.wrGo      = wrGo;
    stb.rdGo      = rdGo;
    stb.fnChan    = newChan;
    stb.maskStb   = fnWr && (newOp == OP_MASK) && newChanOk;
    stb.unmaskStb = fnWr && (newOp == OP_UNMASK) && newChanOk;
    stb.clearStb  = fnWr && (newOp == OP_CLEAR);
  end

  // R1
  fn_seq_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    fnWr |=> (idxQ == 2'd0) && (opQ == $past(newOp)));

  // R8
  seq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((exeWrRaw || exeRdRaw) && !inRange) |=> $stable(idxQ));

endmodule

// File: rtl/dma_cmd_dp.sv
module dma_cmd_dp
  import dma_cmd_pkg::*;
#(
  parameter int NCH = 8   // 1..8: status fits one byte
) (
  input  logic            clk,
  input  logic            rstN,
  input  cmd_stb_t        stb,
  input  logic [7:0]      wdata,
  input  logic [NCH-1:0]  tcPulse,
  output logic [7:0]      rdByte,
  output logic [24*NCH-1:0] chAddr,
  output logic [16*NCH-1:0] chCount,
  output logic [16*NCH-1:0] chIoPort,
  output logic [8*NCH-1:0]  chMode,
  output logic [4*NCH-1:0]  chArb,
  output logic [NCH-1:0]    chMask
);

  logic [NCH-1:0] tcQ, rdClr;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [23:0] addrQ;
    logic [15:0] cntQ, ioQ;
    logic [7:0]  modeQ;
    logic [3:0]  arbQ;
    logic        maskQ;
    logic        hit, fnHit;

    assign hit   = stb.wrGo && (stb.chan == 4'(i));
    assign fnHit = (stb.fnChan == 4'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        addrQ <= '0; cntQ <= '0; ioQ <= '0; modeQ <= '0; arbQ <= '0; maskQ <= 1'b1;
      end else if (stb.clearStb) begin
        addrQ <= '0; cntQ <= '0; ioQ <= '0; modeQ <= '0; arbQ <= '0; maskQ <= 1'b1;
      end else begin
        if (hit) begin
          case (stb.op)
            OP_SET_ADDR: begin
              case (stb.byteIdx)
                2'd0:    addrQ[7:0]   <= wdata;
                2'd1:    addrQ[15:8]  <= wdata;
                default: addrQ[23:16] <= wdata;
              endcase
            end
            OP_SET_CNT: begin
              if (stb.byteIdx[0]) cntQ[15:8] <= wdata;
              else                cntQ[7:0]  <= wdata;
            end
            OP_SET_IO: begin
              if (stb.byteIdx[0]) ioQ[15:8] <= wdata;
              else                ioQ[7:0]  <= wdata;
            end
            OP_SET_MODE: modeQ <= wdata;
            OP_SET_ARB:  arbQ  <= wdata[3:0];
            default: ;
          endcase
        end
        if (stb.maskStb && fnHit)        maskQ <= 1'b1;
        else if (stb.unmaskStb && fnHit) maskQ <= 1'b0;
      end
    end

    assign chAddr[i*24 +: 24]   = addrQ;
    assign chCount[i*16 +: 16]  = cntQ;
    assign chIoPort[i*16 +: 16] = ioQ;
    assign chMode[i*8 +: 8]     = modeQ;
    assign chArb[i*4 +: 4]      = arbQ;
    assign chMask[i]            = maskQ;

    // R10
    tc_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
      (tcPulse[i] && !stb.clearStb) |=> tcQ[i]);

    // R7
    unmask_chk: assert property (@(posedge clk) disable iff (!rstN)
      (stb.unmaskStb && fnHit) |=> !maskQ);
  end

  // sticky terminal-count flags, cleared by the status read that returns them
  assign rdClr = (stb.rdGo && (stb.op == OP_GET_STAT)) ? tcQ : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              tcQ <= '0;
    else if (stb.clearStb)  tcQ <= '0;
    else                    tcQ <= (tcQ & ~rdClr) | tcPulse;
  end

  // read byte of the selected register
  int          chIdx;
  logic [23:0] curAddr;
  logic [15:0] curCnt;

  always_comb begin
    chIdx   = (int'(stb.chan) < NCH) ? int'(stb.chan) : 0;
    curAddr = chAddr[chIdx*24 +: 24];
    curCnt  = chCount[chIdx*16 +: 16];
    case (stb.op)
      OP_GET_ADDR: begin
        case (stb.byteIdx)
          2'd0:    rdByte = curAddr[7:0];
          2'd1:    rdByte = curAddr[15:8];
          default: rdByte = curAddr[23:16];
        endcase
      end
      OP_GET_CNT:  rdByte = stb.byteIdx[0] ? curCnt[15:8] : curCnt[7:0];
      OP_GET_STAT: rdByte = 8'(tcQ);
      default:     rdByte = 8'h00;
    endcase
  end

  // R9
  clear_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.clearStb |=> (&chMask) && (chAddr == '0) && (tcQ == '0));

endmodule

// File: rtl/dma_cmd_front.sv
module dma_cmd_front
  import dma_cmd_pkg::*;
#(
  parameter int NCH = 8,
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] FN_OFS = ADDR_W'(8'h18),
  parameter logic [ADDR_W-1:0] EXE_OFS = ADDR_W'(8'h1A)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [7:0]        hostWdata,
  output logic [7:0]        hostRdata,
  input  logic [NCH-1:0]    tcPulse,
  output logic [24*NCH-1:0] chAddr,
  output logic [16*NCH-1:0] chCount,
  output logic [16*NCH-1:0] chIoPort,
  output logic [8*NCH-1:0]  chMode,
  output logic [4*NCH-1:0]  chArb,
  output logic [NCH-1:0]    chMask
);

  cmd_stb_t   stb;
  logic [7:0] rdByte;

  dma_cmd_ctrl #(.NCH(NCH), .ADDR_W(ADDR_W), .FN_OFS(FN_OFS), .EXE_OFS(EXE_OFS)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .stb(stb)
  );

  dma_cmd_dp #(.NCH(NCH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(hostWdata), .tcPulse(tcPulse),
    .rdByte(rdByte), .chAddr(chAddr), .chCount(chCount), .chIoPort(chIoPort),
    .chMode(chMode), .chArb(chArb), .chMask(chMask)
  );

  assign hostRdata = stb.rdGo ? rdByte : 8'h00;

  // R11
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(hostRd && !hostWr && (hostAddr == EXE_OFS)) |-> (hostRdata == 8'h00));

endmodule

// File: tb/tb_dma_cmd_front.sv
module tb_dma_cmd_front;

  localparam int NCH = 8;
  localparam logic [4:0] FN  = 5'h18;
  localparam logic [4:0] EXE = 5'h1A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWr = 1'b0, hostRd = 1'b0;
  logic [4:0] hostAddr = '0;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata;
  logic [NCH-1:0] tcPulse = '0;
  logic [24*NCH-1:0] chAddr;
  logic [16*NCH-1:0] chCount, chIoPort;
  logic [8*NCH-1:0] chMode;
  logic [4*NCH-1:0] chArb;
  logic [NCH-1:0] chMask;

  int checks = 0;
  int errors = 0;
  logic [7:0] expQ[$];
  string tagQ[$];

  always #5 clk = ~clk;

  dma_cmd_front dut (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .tcPulse(tcPulse),
    .chAddr(chAddr), .chCount(chCount), .chIoPort(chIoPort), .chMode(chMode),
    .chArb(chArb), .chMask(chMask)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic rd, input logic [4:0] a,
                     input logic [7:0] d, input logic [NCH-1:0] tc);
    hostWr = wr; hostRd = rd; hostAddr = a; hostWdata = d; tcPulse = tc;
    @(posedge clk); #2;
    hostWr = 1'b0; hostRd = 1'b0; hostAddr = '0; hostWdata = '0; tcPulse = '0;
  endtask

  task automatic fn(input logic [3:0] op, input logic [3:0] ch);
    acc(1'b1, 1'b0, FN, {op, ch}, '0);
  endtask

  task automatic exeW(input logic [7:0] d);
    acc(1'b1, 1'b0, EXE, d, '0);
  endtask

  task automatic rdAt(input logic [4:0] a, input logic [7:0] exp, input string tag,
                      input logic [NCH-1:0] tc);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    acc(1'b0, 1'b1, a, 8'h00, tc);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && hostRd) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R3 unexpected read got %0h expected none", hostRdata);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if (hostRdata !== e) begin
          errors++;
          $display("FAIL %s got %0h expected %0h", t, hostRdata, e);
        end
      end
    end else if (rstN && hostWr) begin
      checks++;
      if (hostRdata !== 8'h00) begin
        errors++;
        $display("FAIL R11 rdata in write cycle got %0h expected 0", hostRdata);
      end
    end
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;

    // R9 reset state
    chk("R9 reset mask", 32'(chMask), 32'hFF);
    chk("R9 reset addr2", 32'(chAddr[2*24 +: 24]), 32'h0);
    fn(4'h6, 4'h0);
    rdAt(EXE, 8'h00, "R9 reset status", '0);

    // R2 address write, LSB first
    fn(4'h2, 4'h2);
    exeW(8'h56); exeW(8'h34); exeW(8'h12);
    chk("R2 addr ch2", 32'(chAddr[2*24 +: 24]), 32'h123456);
    chk("R2 addr ch1 untouched", 32'(chAddr[1*24 +: 24]), 32'h0);
    // R8 extra write ignored
    exeW(8'hFF);
    chk("R8 extra addr write", 32'(chAddr[2*24 +: 24]), 32'h123456);

    // R3 address read, R8 extra read gives zero
    fn(4'h3, 4'h2);
    rdAt(EXE, 8'h56, "R3 addr b0", '0);
    rdAt(EXE, 8'h34, "R3 addr b1", '0);
    rdAt(EXE, 8'h12, "R3 addr b2", '0);
    rdAt(EXE, 8'h00, "R8 addr extra read", '0);

    // R4 count write and read
    fn(4'h4, 4'h5);
    exeW(8'hCD); exeW(8'hAB);
    chk("R4 count ch5", 32'(chCount[5*16 +: 16]), 32'hABCD);
    fn(4'h5, 4'h5);
    rdAt(EXE, 8'hCD, "R4 count b0", '0);
    rdAt(EXE, 8'hAB, "R4 count b1", '0);

    // R1 function write restarts a partial sequence
    fn(4'h4, 4'h1);
    exeW(8'h11);
    fn(4'h4, 4'h1);
    exeW(8'h22); exeW(8'h33);
    chk("R1 restart count ch1", 32'(chCount[1*16 +: 16]), 32'h3322);

    // R5 I/O port
    fn(4'h0, 4'h0);
    exeW(8'h78); exeW(8'h56);
    chk("R5 io ch0", 32'(chIoPort[0 +: 16]), 32'h5678);

    // R6 mode and arbitration
    fn(4'h7, 4'h7);
    exeW(8'h49); exeW(8'hFF);
    chk("R6 mode ch7", 32'(chMode[7*8 +: 8]), 32'h49);
    fn(4'h8, 4'h3);
    exeW(8'hA5);
    chk("R6 arb ch3", 32'(chArb[3*4 +: 4]), 32'h5);

    // R7 mask / unmask on function write alone
    fn(4'hA, 4'h2);
    fn(4'hA, 4'h4);
    chk("R7 unmask 2,4", 32'(chMask), 32'hEB);
    fn(4'h9, 4'h4);
    chk("R7 mask 4", 32'(chMask), 32'hFB);
    fn(4'hA, 4'hC);
    chk("R7 unmask out of range", 32'(chMask), 32'hFB);
    fn(4'h2, 4'hC);
    exeW(8'h77);
    chk("R7 exe out of range ch2", 32'(chAddr[2*24 +: 24]), 32'h123456);
    chk("R7 exe out of range ch0", 32'(chAddr[0 +: 24]), 32'h0);

    // R1 other offsets ignored
    acc(1'b1, 1'b0, 5'h19, 8'hA0, '0);
    chk("R1 other offset", 32'(chMask), 32'hFB);

    // R8 write during read op ignored, sequence not advanced
    fn(4'h3, 4'h2);
    exeW(8'h00);
    rdAt(EXE, 8'h56, "R8 wrong-dir write", '0);
    chk("R8 wrong-dir addr", 32'(chAddr[2*24 +: 24]), 32'h123456);
    // R8 read during write op returns zero
    fn(4'h2, 4'h2);
    rdAt(EXE, 8'h00, "R8 read in write op", '0);
    // R11 read of function port returns zero
    rdAt(FN, 8'h00, "R11 fn port read", '0);

    // R10 status with a colliding terminal-count pulse
    acc(1'b0, 1'b0, 5'h00, 8'h00, 8'h42);
    fn(4'h6, 4'h0);
    rdAt(EXE, 8'h42, "R10 status first", 8'h08);
    rdAt(EXE, 8'h08, "R10 status collided", '0);
    rdAt(EXE, 8'h00, "R10 status cleared", '0);

    // R9 master clear
    acc(1'b0, 1'b0, 5'h00, 8'h00, 8'h01);
    fn(4'hD, 4'h0);
    exeW(8'h99);
    chk("R9 clear mask", 32'(chMask), 32'hFF);
    chk("R9 clear addr2", 32'(chAddr[2*24 +: 24]), 32'h0);
    chk("R9 clear count5", 32'(chCount[5*16 +: 16]), 32'h0);
    chk("R9 clear io0", 32'(chIoPort[0 +: 16]), 32'h0);
    chk("R9 clear mode7", 32'(chMode[7*8 +: 8]), 32'h0);
    chk("R9 clear arb3", 32'(chArb[3*4 +: 4]), 32'h0);
    fn(4'h6, 4'h0);
    rdAt(EXE, 8'h00, "R9 clear status", '0);
    fn(4'h3, 4'h2);
    rdAt(EXE, 8'h00, "R9 clear addr read", '0);

    @(posedge clk); #2;
    chk("R3 scoreboard drained", 32'(expQ.size()), 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule